// File: doc/BRIEF.md
# Remote Frame Auto-Response Sequencer

This block runs the work that follows a validated incoming frame on a controller area network node. A strobe arrives at the validation point of the frame, the sixth end-of-frame bit. The strobe comes with three things: a flag saying whether the hidden receive buffer matched a receive message buffer, that buffer's index, and a per-buffer identifier match vector. The sequencer then runs up to three steps in a fixed order, each with a fixed cycle cost. First it copies the hidden buffer into the matching message buffer, which takes 17 cycles. Next it converts each matching transmit buffer that is waiting for a remote request into a transmit-once buffer, at 3 cycles per buffer. Last it schedules one buffer for transmission, which takes 2 cycles.

The update and schedule steps run only when the received frame is a remote frame (RTR set). In that case the buffers it releases send their data frames, with RTR cleared. A data frame only triggers the copy step. The worst case is one copy, 14 updates and one schedule, which is 61 cycles. This must fit within four bit times, so it sets the minimum clock for a given bus rate. The typical case is one copy, one update and one schedule, which is 22 cycles.

Top module: `remote_reply_seq`

## Requirements
- R1: After reset, busy, overrun, copyActive, updEn and txReq are all low.
- R2: When frameValid is sampled high while idle and rxMatch is high, copyActive is high for exactly 17 consecutive cycles, starting in the cycle after that edge. During those cycles copyIdx equals the rxBufIdx that was sampled with the strobe.
- R3: Each buffer status is a 2-bit code, with buffer i at statusIn[2i+1:2i]. Code 2'b10 means waiting for a remote request. For a remote frame, every buffer whose txMatch bit is set and whose code is 2'b10 at the strobe gets exactly one updEn pulse, and no other buffer gets one. The pulses come in ascending index order.
- R4: Each update occupies a 3-cycle slot, and updEn pulses for one cycle in the last cycle of its slot. The first slot starts right after the copy step, or right after the strobe when there is no copy.
- R5: After at least one update, a 2-cycle schedule step follows. txReq pulses once, in the last cycle of that step, with txIdx equal to the lowest buffer index that was updated.
- R6: If no buffer is updated, txReq never rises.
- R7: When remoteFrame is low at the strobe, no update and no schedule take place, even if matching buffers hold code 2'b10.
- R8: busy is high for exactly 17·c + 3·n + 2·s consecutive cycles, starting the cycle after the strobe. Here c is 1 if a copy occurs, n is the number of updates, and s is 1 if a schedule occurs. This gives 22 cycles in the typical case and 61 in the worst case.
- R9: A frameValid pulse sampled while busy is high makes overrun pulse high in the next cycle. That pulse leaves the running sequence unchanged.
- R10: A strobe with no copy and nothing to update leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameValid | input | 1 | One-cycle strobe at the frame validation point |
| remoteFrame | input | 1 | Received frame is a remote request |
| rxMatch | input | 1 | Hidden buffer matched a receive message buffer |
| rxBufIdx | input | IDX_W | Index of the matched receive buffer |
| txMatch | input | NUM_BUF | Per-buffer identifier match flags |
| statusIn | input | 2·NUM_BUF | Per-buffer 2-bit status codes |
| busy | output | 1 | Sequence in progress |
| overrun | output | 1 | One-cycle pulse: strobe arrived while busy |
| copyActive | output | 1 | Copy step in progress |
| copyIdx | output | IDX_W | Destination buffer of the copy |
| updEn | output | 1 | Write the transmit-once code to buffer updIdx |
| updIdx | output | IDX_W | Buffer being updated |
| txReq | output | 1 | One-cycle transmission request |
| txIdx | output | IDX_W | Buffer scheduled for transmission |

## Verification
The hardest cases to reach are the worst-case 61-cycle run and an overrun that lands in the middle of a copy. The bench reaches the first with fourteen consecutive matching, waiting buffers, and the second by pulsing frameValid a few cycles into a running copy. It then checks that the update timing and the transmit index match an undisturbed run. The skip logic gets its own case, in which a matching buffer holds a code other than waiting-for-remote, so the bench can confirm that the buffer is passed over without costing a slot.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int unsigned ST_W = 2;
  localparam logic [ST_W-1:0] ST_WAIT_REMOTE = 2'b10;

  typedef enum logic [1:0] {PH_IDLE, PH_COPY, PH_UPD, PH_SCHED} phase_t;

  typedef struct packed {
    logic load;    // capture frame context at the strobe
    logic retire;  // current buffer updated, drop it from the pending set
  } seqCmd_t;
endpackage

// File: rtl/rfs_datapath.sv
module rfs_datapath
  import rfs_pkg::*;
#(
  parameter int unsigned NUM_BUF = 15,
  parameter int unsigned IDX_W   = $clog2(NUM_BUF)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqCmd_t                 cmd,
  input  logic                    remoteFrame,
  input  logic [IDX_W-1:0]        rxBufIdx,
  input  logic [NUM_BUF-1:0]      txMatch,
  input  logic [ST_W*NUM_BUF-1:0] statusIn,
  output logic                    startAny,
  output logic                    pendAny,
  output logic                    pendOthers,
  output logic [IDX_W-1:0]        nextIdx,
  output logic [IDX_W-1:0]        firstIdx,
  output logic [IDX_W-1:0]        rxIdxQ
);
  logic [NUM_BUF-1:0] waitMask;
  logic [NUM_BUF-1:0] startMask;
  logic [NUM_BUF-1:0] pend;
  logic [NUM_BUF-1:0] pendClr;
  logic [IDX_W-1:0]   startLow;

  for (genvar g = 0; g < NUM_BUF; g++) begin : gWait
    assign waitMask[g] = (statusIn[ST_W*g +: ST_W] == ST_WAIT_REMOTE);
  end

  assign startMask = remoteFrame ? (txMatch & waitMask) : '0;
  assign startAny  = |startMask;
  assign pendAny   = |pend;

  function automatic logic [IDX_W-1:0] lowestSet(input logic [NUM_BUF-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign startLow = lowestSet(startMask);
  assign nextIdx  = lowestSet(pend);

  always_comb begin
    pendClr          = pend;
    pendClr[nextIdx] = 1'b0;
  end
  assign pendOthers = |pendClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      firstIdx <= '0;
      rxIdxQ   <= '0;
    end else if (cmd.load) begin
      pend     <= startMask;
      firstIdx <= startLow;
      rxIdxQ   <= rxBufIdx;
    end else if (cmd.retire) begin
      pend     <= pendClr;
    end
  end
endmodule

// File: rtl/rfs_control.sv
module rfs_control
  import rfs_pkg::*;
#(
  parameter int unsigned COPY_CYC  = 17,
  parameter int unsigned UPD_CYC   = 3,
  parameter int unsigned SCHED_CYC = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameValid,
  input  logic    rxMatch,
  input  logic    startAny,
  input  logic    pendAny,
  input  logic    pendOthers,
  output seqCmd_t cmd,
  output logic    busy,
  output logic    overrun,
  output logic    copyActive,
  output logic    updEn,
  output logic    txReq
);
  localparam int unsigned CNT_W = $clog2(COPY_CYC + UPD_CYC + SCHED_CYC);
  localparam logic [CNT_W-1:0] COPY_LAST  = CNT_W'(COPY_CYC - 1);
  localparam logic [CNT_W-1:0] UPD_LAST   = CNT_W'(UPD_CYC - 1);
  localparam logic [CNT_W-1:0] SCHED_LAST = CNT_W'(SCHED_CYC - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             lastCyc;

  always_comb begin
    case (phase)
      PH_COPY:  lastCyc = (cnt == COPY_LAST);
      PH_UPD:   lastCyc = (cnt == UPD_LAST);
      PH_SCHED: lastCyc = (cnt == SCHED_LAST);
      default:  lastCyc = 1'b0;
    endcase
  end

  assign busy       = (phase != PH_IDLE);
  assign copyActive = (phase == PH_COPY);
  assign updEn      = (phase == PH_UPD) && lastCyc;
  assign txReq      = (phase == PH_SCHED) && lastCyc;
  assign cmd.load   = (phase == PH_IDLE) && frameValid;
  assign cmd.retire = updEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= frameValid && busy;
      if (phase == PH_IDLE) begin
        cnt <= '0;
        if (frameValid) begin
          if (rxMatch)       phase <= PH_COPY;
          else if (startAny) phase <= PH_UPD;
        end
      end else if (lastCyc) begin
        cnt <= '0;
        case (phase)
          PH_COPY: phase <= pendAny ? PH_UPD : PH_IDLE;
          PH_UPD:  phase <= pendOthers ? PH_UPD : PH_SCHED;
          default: phase <= PH_IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/remote_reply_seq.sv
module remote_reply_seq
  import rfs_pkg::*;
#(
  parameter int unsigned NUM_BUF   = 15,
  parameter int unsigned COPY_CYC  = 17,
  parameter int unsigned UPD_CYC   = 3,
  parameter int unsigned SCHED_CYC = 2,
  parameter int unsigned IDX_W     = $clog2(NUM_BUF)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameValid,
  input  logic                    remoteFrame,
  input  logic                    rxMatch,
  input  logic [IDX_W-1:0]        rxBufIdx,
  input  logic [NUM_BUF-1:0]      txMatch,
  input  logic [ST_W*NUM_BUF-1:0] statusIn,
  output logic                    busy,
  output logic                    overrun,
  output logic                    copyActive,
  output logic [IDX_W-1:0]        copyIdx,
  output logic                    updEn,
  output logic [IDX_W-1:0]        updIdx,
  output logic                    txReq,
  output logic [IDX_W-1:0]        txIdx
);
  seqCmd_t cmd;
  logic    startAny;
  logic    pendAny;
  logic    pendOthers;

  rfs_control #(
    .COPY_CYC (COPY_CYC),
    .UPD_CYC  (UPD_CYC),
    .SCHED_CYC(SCHED_CYC)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameValid(frameValid),
    .rxMatch   (rxMatch),
    .startAny  (startAny),
    .pendAny   (pendAny),
    .pendOthers(pendOthers),
    .cmd       (cmd),
    .busy      (busy),
    .overrun   (overrun),
    .copyActive(copyActive),
    .updEn     (updEn),
    .txReq     (txReq)
  );

  rfs_datapath #(
    .NUM_BUF(NUM_BUF),
    .IDX_W  (IDX_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .remoteFrame(remoteFrame),
    .rxBufIdx   (rxBufIdx),
    .txMatch    (txMatch),
    .statusIn   (statusIn),
    .startAny   (startAny),
    .pendAny    (pendAny),
    .pendOthers (pendOthers),
    .nextIdx    (updIdx),
    .firstIdx   (txIdx),
    .rxIdxQ     (copyIdx)
  );
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int unsigned NUM_BUF   = 15,
  parameter int unsigned COPY_CYC  = 17,
  parameter int unsigned UPD_CYC   = 3,
  parameter int unsigned SCHED_CYC = 2,
  parameter int unsigned IDX_W     = $clog2(NUM_BUF)
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameValid,
  input logic             busy,
  input logic             overrun,
  input logic             copyActive,
  input logic             updEn,
  input logic [IDX_W-1:0] updIdx,
  input logic             txReq
);
  localparam int unsigned MAX_RUN = COPY_CYC + NUM_BUF * UPD_CYC + SCHED_CYC;

  int unsigned      runLen;
  int unsigned      copyLen;
  logic             seenUpd;
  logic [IDX_W-1:0] lastUpd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen  <= 0;
      copyLen <= 0;
      seenUpd <= 1'b0;
      lastUpd <= '0;
    end else begin
      runLen  <= busy ? runLen + 1 : 0;
      copyLen <= copyActive ? copyLen + 1 : 0;
      if (!busy) seenUpd <= 1'b0;
      else if (updEn) begin
        seenUpd <= 1'b1;
        lastUpd <= updIdx;
      end
    end
  end

  // R1: the three step outputs never overlap
  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({copyActive, updEn, txReq}));

  // R2: a copy run lasts exactly COPY_CYC cycles
  a_r2_copy_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(copyActive) |-> copyLen == COPY_CYC);

  // R3: updates are issued in ascending buffer order
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && seenUpd) |-> updIdx > lastUpd);

  // R4: update strobes are single-cycle pulses
  a_r4_upd_pulse: assert property (@(posedge clk) disable iff (!rstN)
    updEn |=> !updEn);

  // R5: the transmit request ends the busy period
  a_r5_tx_ends: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> !busy);

  // R8: no run exceeds the worst-case budget
  a_r8_budget: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> runLen < MAX_RUN);

  // R9: a strobe while busy raises overrun next cycle
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && busy) |=> overrun);
endmodule

bind remote_reply_seq rfs_checker #(
  .NUM_BUF  (NUM_BUF),
  .COPY_CYC (COPY_CYC),
  .UPD_CYC  (UPD_CYC),
  .SCHED_CYC(SCHED_CYC),
  .IDX_W    (IDX_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .frameValid(frameValid),
  .busy      (busy),
  .overrun   (overrun),
  .copyActive(copyActive),
  .updEn     (updEn),
  .updIdx    (updIdx),
  .txReq     (txReq)
);

// File: tb/tb_remote_reply_seq.sv
module tb_remote_reply_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_BUF = 15;
  localparam int IDX_W = $clog2(NUM_BUF);
  localparam int COPY_CYC = 17;
  localparam int UPD_CYC = 3;
  localparam int SCHED_CYC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0;
  logic remoteFrame = 1'b0;
  logic rxMatch = 1'b0;
  logic [IDX_W-1:0] rxBufIdx = '0;
  logic [NUM_BUF-1:0] txMatch = '0;
  logic [2*NUM_BUF-1:0] statusIn = '0;
  logic busy, overrun, copyActive, updEn, txReq;
  logic [IDX_W-1:0] copyIdx, updIdx, txIdx;

  int testCnt = 0;
  int failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  remote_reply_seq dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .remoteFrame(remoteFrame),
    .rxMatch(rxMatch), .rxBufIdx(rxBufIdx), .txMatch(txMatch), .statusIn(statusIn),
    .busy(busy), .overrun(overrun), .copyActive(copyActive), .copyIdx(copyIdx),
    .updEn(updEn), .updIdx(updIdx), .txReq(txReq), .txIdx(txIdx)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // builds status codes: 2'b10 where waitBits set, 2'b01 elsewhere
  function automatic logic [2*NUM_BUF-1:0] mkStatus(input logic [NUM_BUF-1:0] waitBits);
    logic [2*NUM_BUF-1:0] s;
    for (int i = 0; i < NUM_BUF; i++) s[2*i +: 2] = waitBits[i] ? 2'b10 : 2'b01;
    return s;
  endfunction

  task automatic runSeq(input string name, input logic rx, input logic rem,
                        input logic [IDX_W-1:0] rIdx, input logic [NUM_BUF-1:0] match,
                        input logic [NUM_BUF-1:0] waitBits, input int injectAt);
    logic [NUM_BUF-1:0] pendE;
    int expIdx[NUM_BUF];
    int n = 0, c, s, expBusy, firstE = 0;
    int busyCnt = 0, busyBad = 0, copyCnt = 0, copyIdxBad = 0;
    int updCnt = 0, updBad = 0, txCnt = 0, txBad = 0, ovCnt = 0, ovBad = 0;
    pendE = rem ? (match & waitBits) : '0;
    for (int i = 0; i < NUM_BUF; i++) if (pendE[i]) begin expIdx[n] = i; n++; end
    if (n > 0) firstE = expIdx[0];
    c = rx ? 1 : 0;
    s = (n > 0) ? 1 : 0;
    expBusy = COPY_CYC*c + UPD_CYC*n + SCHED_CYC*s;

    @(negedge clk);
    rxMatch = rx; remoteFrame = rem; rxBufIdx = rIdx;
    txMatch = match; statusIn = mkStatus(waitBits); frameValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frameValid = 1'b0;
    for (int j = 1; j <= 90; j++) begin
      if (busy) busyCnt++;
      if (busy != (j <= expBusy)) busyBad++;
      if (copyActive) begin
        copyCnt++;
        if (copyIdx != rIdx || j > COPY_CYC*c) copyIdxBad++;
      end
      if (updEn) begin
        if (updCnt >= n) updBad++;
        else if (updIdx != IDX_W'(expIdx[updCnt]) ||
                 j != COPY_CYC*c + UPD_CYC*(updCnt+1)) updBad++;
        updCnt++;
      end
      if (txReq) begin
        txCnt++;
        if (txIdx != IDX_W'(firstE) || j != expBusy) txBad++;
      end
      if (overrun) begin
        ovCnt++;
        if (j != injectAt + 1) ovBad++;
      end
      if (injectAt > 0 && j == injectAt) frameValid = 1'b1;
      if (injectAt > 0 && j == injectAt + 1) frameValid = 1'b0;
      @(negedge clk);
    end
    check(busyCnt == expBusy && busyBad == 0, "R8", {name, " busy length"}, busyCnt, expBusy);
    if (expBusy == 0) check(busyCnt == 0, "R10", {name, " idle strobe"}, busyCnt, 0);
    check(copyCnt == COPY_CYC*c, "R2", {name, " copy cycles"}, copyCnt, COPY_CYC*c);
    check(copyIdxBad == 0, "R2", {name, " copy index/timing"}, copyIdxBad, 0);
    check(updCnt == n, "R3", {name, " update count"}, updCnt, n);
    check(updBad == 0, "R4", {name, " update order/slot timing"}, updBad, 0);
    if (!rem) check(updCnt == 0 && txCnt == 0, "R7", {name, " data frame side effects"},
                    updCnt + txCnt, 0);
    if (n > 0) check(txCnt == 1 && txBad == 0, "R5", {name, " schedule"}, txCnt, 1);
    else check(txCnt == 0, "R6", {name, " no schedule"}, txCnt, 0);
    check(ovCnt == (injectAt > 0 ? 1 : 0) && ovBad == 0, "R9", {name, " overrun"},
          ovCnt, injectAt > 0 ? 1 : 0);
  endtask

  task automatic testReset();
    check(!busy && !overrun && !copyActive && !updEn && !txReq, "R1", "reset outputs",
          int'({busy, overrun, copyActive, updEn, txReq}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // typical: copy + one update + schedule = 22 cycles
    runSeq("typical", 1'b1, 1'b1, 4'd3, 15'h0020, 15'h7FFF, 0);
    // worst: copy + 14 updates + schedule = 61 cycles
    runSeq("worst", 1'b1, 1'b1, 4'd0, 15'h7FFE, 15'h7FFF, 0);
    // no copy, matching buffer 7 not waiting is skipped (R3)
    runSeq("skip", 1'b0, 1'b1, 4'd9, 15'h4084, 15'h4004, 0);
    // data frame: copy only (R7)
    runSeq("data", 1'b1, 1'b0, 4'd11, 15'h7FFF, 15'h7FFF, 0);
    // remote frame with no matching buffer, no copy (R10, R6)
    runSeq("empty", 1'b0, 1'b1, 4'd2, 15'h0000, 15'h7FFF, 0);
    // copy but waiting buffers do not match (R6)
    runSeq("nomatch", 1'b1, 1'b1, 4'd14, 15'h0003, 15'h7FF0, 0);
    // overrun strobe during copy (R9)
    runSeq("overrun", 1'b1, 1'b1, 4'd6, 15'h0300, 15'h7FFF, 4);
    testReset();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule